// File: doc/BRIEF.md
# SPI Burst Memory Access Controller

This block is an SPI target that lets an external host read and write every on-chip memory, including the configuration register file, over four pins. Each transaction begins with a 32-bit command word. The command word picks the direction, one of sixteen memory targets, a 16-bit start word address and a burst length. Data words then follow. For a write they arrive on MOSI. For a read they leave on MISO. The word address steps by one after every word.

The SPI pins are brought into the system clock domain by a two-flop synchroniser, and all edge detection runs on the system clock. On the memory side the block drives a generic request bus: a memory select, a word address, a one-cycle write strobe with write data, and a one-cycle read strobe whose data is returned one clock later. Reads are fetched one word ahead, so MISO never waits on memory. The layer count, the per-layer kernel sizes and the other configuration values are programmed in exactly the same way as any other memory; they are simply one select value among the sixteen.

Top module: `spi_burst_ctrl`

## Requirements
- R1: While reset is held and after it is released, with chip select high, `spi_miso`, `mem_wr_en` and `mem_rd_en` are all 0.
- R2: The command word is sent MSB first in SPI mode 0. Bit 31 is 1 for a write and 0 for a read. Bits 30:27 give the memory select, driven on `mem_sel`. Bits 26:11 give the start word address. Bits 10:0 give the count N. MISO stays 0 while the command word is shifted in.
- R3: A count of N moves exactly N+1 words (all ones means 2048). Data clocked after the last word causes no memory access, and MISO reads 0 during that time.
- R4: After each word the address increases by one, and the address after 0xFFFF is 0x0000.
- R5: In a write, every 16 MOSI bits, MSB first, give one single-cycle `mem_wr_en` pulse carrying the selected memory, the current address and the assembled word.
- R6: In a read, MISO presents each word MSB first. It changes only after SCLK falling edges. The first bit of the first word is valid before the first SCLK rising edge after the command word.
- R7: A read issues `mem_rd_en` for the start address as soon as the command word completes. It issues the next address when each word completes, but only while words of the burst remain. Read data is taken one clock after the strobe.
- R8: Raising CS_n ends any burst, discards a partly received word and clears the command shift register, so the next transaction decodes a fresh command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| mem_sel | output | 4 | Target memory select |
| mem_addr | output | 16 | Word address |
| mem_wr_en | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rd_en | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 16 | Read data, valid one clock after `mem_rd_en` |

## Verification
The bench holds a behavioural memory model, a queue of expected write and read requests, and an SPI host. Each clock it compares the request bus with those queues. Several burst patterns are used:
- Short and long bursts written and then read back show that the fields decode correctly and that the address steps and MISO ordering are right.
- A burst that starts at 0xFFFE exposes the address wrap.
- The same address written under two different selects, one of them the configuration space, separates the select field from the address field.
- Bursts clocked past their count show whether any access leaks beyond N+1 words.
- Transfers cut short in the command word, inside a write word and inside a read burst separate the abort behaviour from normal completion.

// File: rtl/spi_burst_pkg.sv
// Package: shared types for the SPI burst memory access controller.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_burst_pkg;

    // Transaction phase of the controller.
    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/spi_burst_sync.sv
// Module: spi_burst_sync
// Brings a vector of asynchronous pins into the clk domain through a chain of
// STAGES flops per bit. Assumes the pins change slowly compared with clk.
module spi_burst_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            // Later flops settle any metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_burst_txpath.sv
// Module: spi_burst_txpath
// Read-return path. Captures memory data one clock after a read strobe into a
// prefetch buffer. On a falling SCLK edge it either loads the buffer into the
// output shift register (at a word boundary) or shifts out the next bit, MSB first.
// Assumes each SCLK half period spans at least four clk cycles, so the buffer is
// always filled before it is needed.
module spi_burst_txpath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] rdata,
    input  logic              fall,
    input  logic              load,
    input  logic              active,
    output logic              miso
);

    logic              cap_q;
    logic              buf_v_q;
    logic [DATA_W-1:0] buf_q;
    logic [DATA_W-1:0] shift_q;

    // Prefetch buffer and output shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cap_q   <= 1'b0;
            buf_v_q <= 1'b0;
            buf_q   <= '0;
            shift_q <= '0;
        end else begin
            cap_q <= rd_issue;
            if (fall && active) begin
                if (load) begin
                    shift_q <= buf_q;
                    buf_v_q <= 1'b0;
                end else begin
                    shift_q <= {shift_q[DATA_W-2:0], 1'b0};
                end
            end
            if (cap_q) begin
                buf_q   <= rdata;
                buf_v_q <= 1'b1;
            end
        end
    end

    assign miso = active & shift_q[DATA_W-1];

    // R7: a word boundary never finds the prefetch buffer empty.
    a_r7_prefetch_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && active && load && !clear) |-> buf_v_q);

endmodule

// File: rtl/spi_burst_ctrl.sv
// Module: spi_burst_ctrl (top)
// SPI mode-0 target that decodes a 32-bit command word {wr, sel, addr, count}
// and then runs a burst of count+1 words to or from the selected memory. The
// address steps by one per word and wraps at the top of the address range.
// Assumes SCLK is oversampled by clk with half periods of at least four clk
// cycles, and that the memory returns read data one clk after mem_rd_en.
module spi_burst_ctrl
    import spi_burst_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 16,
    parameter int SEL_W       = 4,
    parameter int CNT_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [SEL_W-1:0]  mem_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int HDR_W    = 1 + SEL_W + ADDR_W + CNT_W;
    localparam int MAX_BITS = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int BIT_CW   = $clog2(MAX_BITS);

    logic [2:0] pins_s;
    logic       sclk_s, cs_s, mosi_s, sclk_q;
    logic       rise, fall;

    phase_e             phase_q;
    logic [BIT_CW-1:0]  bit_q;
    logic [HDR_W-2:0]   hdr_q;
    logic [HDR_W-1:0]   hdr_full;
    logic               is_wr_q;
    logic [SEL_W-1:0]   sel_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   left_q;
    logic [DATA_W-2:0]  rx_q;
    logic [DATA_W-1:0]  word;
    logic               wr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               fetch_q;
    logic               rd_mode;

    spi_burst_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sclk, spi_cs_n, spi_mosi}),
        .sync_o  (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign cs_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    // Delayed copy of SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise     = sclk_s & ~sclk_q & ~cs_s;
    assign fall     = ~sclk_s & sclk_q & ~cs_s;
    assign hdr_full = {hdr_q, mosi_s};
    assign word     = {rx_q, mosi_s};

    // Command decode, burst sequencing and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_HDR;
            bit_q   <= '0;
            hdr_q   <= '0;
            is_wr_q <= 1'b0;
            sel_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            rx_q    <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            fetch_q <= 1'b0;
        end else if (cs_s) begin
            phase_q <= PH_HDR;
            bit_q   <= '0;
            hdr_q   <= '0;
            wr_q    <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            wr_q    <= 1'b0;
            fetch_q <= 1'b0;
            if (wr_q) addr_q <= addr_q + ADDR_W'(1);
            if (rise) begin
                unique case (phase_q)
                    PH_HDR: begin
                        hdr_q <= hdr_full[HDR_W-2:0];
                        if (bit_q == BIT_CW'(HDR_W - 1)) begin
                            phase_q <= PH_DATA;
                            bit_q   <= '0;
                            is_wr_q <= hdr_full[HDR_W-1];
                            sel_q   <= hdr_full[HDR_W-2 -: SEL_W];
                            addr_q  <= hdr_full[CNT_W +: ADDR_W];
                            left_q  <= hdr_full[CNT_W-1:0];
                            fetch_q <= ~hdr_full[HDR_W-1];
                        end else begin
                            bit_q <= bit_q + BIT_CW'(1);
                        end
                    end
                    PH_DATA: begin
                        rx_q <= word[DATA_W-2:0];
                        if (bit_q == BIT_CW'(DATA_W - 1)) begin
                            bit_q <= '0;
                            if (is_wr_q) begin
                                wr_q    <= 1'b1;
                                wdata_q <= word;
                            end else begin
                                addr_q  <= addr_q + ADDR_W'(1);
                                fetch_q <= (left_q != '0);
                            end
                            if (left_q == '0) phase_q <= PH_DONE;
                            else              left_q  <= left_q - CNT_W'(1);
                        end else begin
                            bit_q <= bit_q + BIT_CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_mode = (phase_q == PH_DATA) && !is_wr_q;

    spi_burst_txpath #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cs_s),
        .rd_issue (fetch_q),
        .rdata    (mem_rdata),
        .fall     (fall),
        .load     (bit_q == '0),
        .active   (rd_mode),
        .miso     (spi_miso)
    );

    assign mem_sel   = sel_q;
    assign mem_addr  = addr_q;
    assign mem_wr_en = wr_q;
    assign mem_wdata = wdata_q;
    assign mem_rd_en = fetch_q;

    // R1: a deselected target issues no memory request.
    a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!mem_wr_en && !mem_rd_en));

    // R3: once the burst is finished no further read is requested.
    a_r3_no_fetch_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |-> !mem_rd_en);

    // R4: every committed write advances the address by one, with wrap.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !cs_s) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R5: write strobes last a single cycle.
    a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    // R7: reads and writes never share a cycle.
    a_r7_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && mem_rd_en));

endmodule

// File: tb/tb_spi_burst_ctrl.sv
`timescale 1ns/1ps
module tb_spi_burst_ctrl;

    localparam int H = 4;  // clk cycles per SCLK half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [3:0]  mem_sel;
    logic [15:0] mem_addr;
    logic        mem_wr_en;
    logic [15:0] mem_wdata;
    logic        mem_rd_en;
    logic [15:0] mem_rdata = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    logic [15:0] store [int];
    logic [35:0] exp_wr [$];
    logic [19:0] exp_rd [$];

    always #2.5 clk = ~clk;

    spi_burst_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .mem_sel   (mem_sel),
        .mem_addr  (mem_addr),
        .mem_wr_en (mem_wr_en),
        .mem_wdata (mem_wdata),
        .mem_rd_en (mem_rd_en),
        .mem_rdata (mem_rdata)
    );

    function automatic int key_of(input logic [3:0] s, input logic [15:0] a);
        return int'({12'd0, s, a});
    endfunction

    function automatic logic [15:0] mem_val(input int k);
        if (store.exists(k)) return store[k];
        return 16'(k * 40503) ^ 16'h1234;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: registered read data one clock after the strobe.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_val(key_of(mem_sel, mem_addr));
    end

    // Reference comparison of the request bus on every clock.
    always @(negedge clk) begin
        if (rst_n && mem_wr_en) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R3 write beyond burst", {28'd0, mem_sel, mem_addr, mem_wdata}, 64'd0);
            end else begin
                logic [35:0] e;
                e = exp_wr.pop_front();
                check({mem_sel, mem_addr, mem_wdata} == e, "R5 write request",
                      {28'd0, mem_sel, mem_addr, mem_wdata}, {28'd0, e});
            end
            store[key_of(mem_sel, mem_addr)] = mem_wdata;
        end
        if (rst_n && mem_rd_en) begin
            if (exp_rd.size() == 0) begin
                check(1'b0, "R7 read beyond burst", {44'd0, mem_sel, mem_addr}, 64'd0);
            end else begin
                logic [19:0] e;
                e = exp_rd.pop_front();
                check({mem_sel, mem_addr} == e, "R7 read request",
                      {44'd0, mem_sel, mem_addr}, {44'd0, e});
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic r);
        spi_mosi = b;
        waitc(H);
        r = spi_miso;
        spi_sclk = 1'b1;
        waitc(H);
        spi_sclk = 1'b0;
    endtask

    task automatic cs_on();
        spi_cs_n = 1'b0;
        waitc(H);
    endtask

    task automatic cs_off();
        waitc(H);
        spi_cs_n = 1'b1;
        waitc(3 * H);
        check(exp_wr.size() == 0, "R8 pending writes after deselect", 64'(exp_wr.size()), 64'd0);
        check(exp_rd.size() == 0, "R7 pending reads after deselect", 64'(exp_rd.size()), 64'd0);
    endtask

    task automatic send_hdr(input logic wr, input logic [3:0] s, input logic [15:0] a,
                            input logic [10:0] n, input int nbits);
        logic [31:0] h;
        logic        r;
        logic        any;
        h   = {wr, s, a, n};
        any = 1'b0;
        for (int i = 31; i > 31 - nbits; i--) begin
            spi_bit(h[i], r);
            any = any | r;
        end
        check(any == 1'b0, "R2 MISO quiet during command", 64'(any), 64'd0);
    endtask

    function automatic logic [15:0] pat(input logic [15:0] seed, input int i);
        return 16'(seed * 16'd3 + 16'(i) * 16'h1111) ^ 16'hA5C3;
    endfunction

    // Write burst: nwords full words then tail extra bits, then deselect.
    task automatic do_write(input logic [3:0] s, input logic [15:0] a, input logic [10:0] n,
                            input logic [15:0] seed, input int nwords, input int tail);
        logic r;
        cs_on();
        send_hdr(1'b1, s, a, n, 32);
        for (int i = 0; i < nwords; i++) begin
            logic [15:0] d;
            d = pat(seed, i);
            if (i <= int'(n)) exp_wr.push_back({s, 16'(a + 16'(i)), d});
            for (int b = 15; b >= 0; b--) spi_bit(d[b], r);
        end
        for (int b = 0; b < tail; b++) spi_bit(1'b1, r);
        cs_off();
    endtask

    // Read burst: clocks nwords words and compares MISO with the model.
    task automatic do_read(input logic [3:0] s, input logic [15:0] a, input logic [10:0] n,
                           input int nwords, input string req);
        logic        r;
        logic [15:0] got;
        for (int j = 0; j <= nwords && j <= int'(n); j++)
            exp_rd.push_back({s, 16'(a + 16'(j))});
        cs_on();
        send_hdr(1'b0, s, a, n, 32);
        for (int i = 0; i < nwords; i++) begin
            for (int b = 15; b >= 0; b--) begin
                spi_bit(1'b0, r);
                got[b] = r;
            end
            if (i <= int'(n))
                check(got == mem_val(key_of(s, 16'(a + 16'(i)))), req, 64'(got),
                      64'(mem_val(key_of(s, 16'(a + 16'(i))))));
            else
                check(got == 16'd0, "R3 MISO quiet after burst", 64'(got), 64'd0);
        end
        cs_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic r;
        waitc(4);
        // R1: reset state.
        check({spi_miso, mem_wr_en, mem_rd_en} == 3'b000, "R1 outputs in reset",
              64'({spi_miso, mem_wr_en, mem_rd_en}), 64'd0);
        rst_n = 1'b1;
        waitc(6);
        check({spi_miso, mem_wr_en, mem_rd_en} == 3'b000, "R1 outputs after reset",
              64'({spi_miso, mem_wr_en, mem_rd_en}), 64'd0);

        // R5/R6: four-word write then read back.
        do_write(4'd3, 16'h0100, 11'd3, 16'h1000, 4, 0);
        do_read(4'd3, 16'h0100, 11'd3, 4, "R6 readback of written burst");

        // R3: single-word read clocked for three words.
        do_read(4'd5, 16'h2000, 11'd0, 3, "R3 single-word read");

        // R3: two-word write followed by extra words that must be ignored.
        do_write(4'd6, 16'h0300, 11'd1, 16'h2222, 4, 0);
        do_read(4'd6, 16'h0300, 11'd3, 4, "R3 words past count untouched");

        // R4: burst across the top of the address range.
        do_write(4'd7, 16'hFFFE, 11'd2, 16'h3333, 3, 0);
        do_read(4'd7, 16'hFFFE, 11'd2, 3, "R4 address wrap");
        do_read(4'd7, 16'h0000, 11'd0, 1, "R4 word at wrapped address");

        // R2: same address under the lowest and the configuration select.
        do_write(4'd0, 16'h0042, 11'd0, 16'h4444, 1, 0);
        do_write(4'd15, 16'h0042, 11'd0, 16'h5555, 1, 0);
        do_read(4'd0, 16'h0042, 11'd0, 1, "R2 select 0 data");
        do_read(4'd15, 16'h0042, 11'd0, 1, "R2 select 15 data");

        // R8: write aborted inside its third word.
        do_write(4'd2, 16'h0040, 11'd5, 16'h6666, 2, 7);
        do_read(4'd2, 16'h0040, 11'd3, 4, "R8 partial word discarded");

        // R8: command word cut short, then a normal transaction.
        cs_on();
        send_hdr(1'b1, 4'd9, 16'hFFFF, 11'h7FF, 10);
        cs_off();
        do_read(4'd3, 16'h0101, 11'd1, 2, "R8 fresh command after abort");

        // R8/R7: read aborted after two of six words.
        do_read(4'd4, 16'h0800, 11'd5, 2, "R8 aborted read");

        // R4/R3: longer burst.
        do_write(4'd1, 16'h1234, 11'd39, 16'h7777, 40, 0);
        do_read(4'd1, 16'h1234, 11'd39, 41, "R4 long burst readback");

        spi_mosi = 1'b0;
        waitc(8);
        check({spi_miso, mem_wr_en, mem_rd_en} == 3'b000, "R1 idle after traffic",
              64'({spi_miso, mem_wr_en, mem_rd_en}), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule